// File: doc/BRIEF.md
# Transmit Fault Alarm Aggregator

This block watches a laser transmitter for fast faults. Each time a sample-valid strobe arrives it compares a digitized bias-current sample and a digitized transmit-power sample against three programmable limits. These are a bias ceiling, a power ceiling and a power floor. Any limit crossed on that sample sets a sticky flag. The flags stay set until a transmit-disable event, which is a rising edge of the synchronized transmit-disable input, clears all three at once.

The three fast flags are merged with an externally generated vector of slow alarms and warnings. Each slow bit is masked by its own enable bit; the fast flags cannot be masked. The result is a fault interrupt. The interrupt drives an open-drain fault pin, modelled here as an output-enable. Two read-only 8-bit status words report the flags, the pin state, the interrupt and an externally supplied shutdown signal. A host-bus front end can read them.

Top module: `txFaultAgg`

## Requirements
- R1: The high-bias flag (statusTwo bit 3) is set by a sample strobe whose bias sample is strictly greater than the bias ceiling. A sample equal to the ceiling does not set it. The flag resets to 0.
- R2: The high-power flag (statusTwo bit 1) is set by a sample strobe whose power sample is strictly greater than the power ceiling. It resets to 0.
- R3: The low-power flag (statusTwo bit 0) is set by a sample strobe whose power sample is strictly less than the power floor. It resets to 0.
- R4: A set flag stays set when later samples lie within the limits.
- R5: A rising edge of txDisable clears all three flags. The flags read 0 after the third rising clock edge that follows the input change. A sample strobe that would set a flag on that same edge loses to the clear.
- R6: faultInt is the OR of (slowAlarms AND slowEnables) over all bits, ORed with the three fast flags. It follows its inputs within the same cycle.
- R7: faultOe is 1 (the pin pulls low) when the interrupt is 0 and 0 (high impedance) when it is 1. statusOne bit 2 reads 1 exactly when the pin is high impedance.
- R8: statusOne holds the pin status in bit 2, shutdownSig in bit 1 and the interrupt in bit 0. Bits 7 to 3 read 0.
- R9: statusTwo holds only the bits of R1 to R3, and all its other bits read 0. Both status words read 00h after reset when the slow alarms and shutdownSig are low.
- R10: Holding txDisable high, or lowering it, does not clear the flags.
- R11: Sample values presented without the sample-valid strobe set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleValid | input | 1 | Strobe that registers the fast comparisons |
| biasSample | input | SAMPLE_W | Digitized bias current |
| powerSample | input | SAMPLE_W | Digitized transmit power |
| biasHiLimit | input | SAMPLE_W | Bias ceiling |
| powerHiLimit | input | SAMPLE_W | Power ceiling |
| powerLoLimit | input | SAMPLE_W | Power floor |
| slowAlarms | input | SLOW_W | Slow alarm and warning levels |
| slowEnables | input | SLOW_W | Per-bit enable for slowAlarms |
| shutdownSig | input | 1 | Internal shutdown signal, reported only |
| txDisable | input | 1 | Asynchronous transmit-disable input |
| faultOe | output | 1 | Open-drain enable of the fault pin (1 = pull low) |
| statusOne | output | 8 | Pin status, shutdown and interrupt word |
| statusTwo | output | 8 | Fast-flag word |

## Verification
The assertions check on every cycle that a clear strobe empties all flags on the next edge, even against a simultaneous set. They also check that each clear strobe lasts one cycle, that an over-limit strobed sample sets its flag, that a set flag persists without a clear, that the pin enable tracks the interrupt and that the unused status bits stay zero. The exact latency of the synchronizer, the equality boundary of the comparisons, the masking of slow alarms, and the fact that a held or falling disable input leaves the flags alone are shown only by the bench's directed scenarios.

// File: rtl/txFaultPkg.sv
package txFaultPkg;
  typedef struct packed {
    logic sampleLatch;
    logic clearFlags;
  } ctrlStrobes_t;
endpackage

// File: rtl/txFaultCtrl.sv
module txFaultCtrl
  import txFaultPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         txDisable,
  output ctrlStrobes_t strobes
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic txdPrev;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= txDisable;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) txdPrev <= 1'b0;
    else       txdPrev <= syncChain[SYNC_STAGES-1];

  always_comb begin
    strobes.clearFlags  = syncChain[SYNC_STAGES-1] & ~txdPrev;
    strobes.sampleLatch = sampleValid;
  end

  // R5: a disable event is a single-cycle pulse
  p_clear_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearFlags |=> !strobes.clearFlags);
endmodule

// File: rtl/txFaultDatapath.sv
module txFaultDatapath
  import txFaultPkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SLOW_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] biasSample,
  input  logic [SAMPLE_W-1:0] powerSample,
  input  logic [SAMPLE_W-1:0] biasHiLimit,
  input  logic [SAMPLE_W-1:0] powerHiLimit,
  input  logic [SAMPLE_W-1:0] powerLoLimit,
  input  logic [SLOW_W-1:0]   slowAlarms,
  input  logic [SLOW_W-1:0]   slowEnables,
  input  logic                shutdownSig,
  output logic                faultInt,
  output logic [7:0]          statusOne,
  output logic [7:0]          statusTwo
);
  logic hiBias, hiPower, loPower;
  logic biasOver, powerOver, powerUnder;
  logic slowHit;

  assign biasOver   = biasSample > biasHiLimit;
  assign powerOver  = powerSample > powerHiLimit;
  assign powerUnder = powerSample < powerLoLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBias  <= 1'b0;
      hiPower <= 1'b0;
      loPower <= 1'b0;
    end else if (strobes.clearFlags) begin
      hiBias  <= 1'b0;
      hiPower <= 1'b0;
      loPower <= 1'b0;
    end else if (strobes.sampleLatch) begin
      hiBias  <= hiBias  | biasOver;
      hiPower <= hiPower | powerOver;
      loPower <= loPower | powerUnder;
    end
  end

  assign slowHit  = |(slowAlarms & slowEnables);
  assign faultInt = slowHit | hiBias | hiPower | loPower;

  always_comb begin
    statusOne    = '0;
    statusOne[2] = faultInt;
    statusOne[1] = shutdownSig;
    statusOne[0] = faultInt;
    statusTwo    = '0;
    statusTwo[3] = hiBias;
    statusTwo[1] = hiPower;
    statusTwo[0] = loPower;
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearFlags |=> (statusTwo == 8'h00));

  p_bias_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleLatch && !strobes.clearFlags && biasOver) |=> hiBias);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clearFlags && (hiBias || hiPower || loPower))
      |=> ((statusTwo & $past(statusTwo)) == $past(statusTwo)));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusOne[7:3] == 5'd0 && statusTwo[7:4] == 4'd0 && statusTwo[2] == 1'b0);
endmodule

// File: rtl/txFaultAgg.sv
module txFaultAgg
  import txFaultPkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int SLOW_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] biasSample,
  input  logic [SAMPLE_W-1:0] powerSample,
  input  logic [SAMPLE_W-1:0] biasHiLimit,
  input  logic [SAMPLE_W-1:0] powerHiLimit,
  input  logic [SAMPLE_W-1:0] powerLoLimit,
  input  logic [SLOW_W-1:0]   slowAlarms,
  input  logic [SLOW_W-1:0]   slowEnables,
  input  logic                shutdownSig,
  input  logic                txDisable,
  output logic                faultOe,
  output logic [7:0]          statusOne,
  output logic [7:0]          statusTwo
);
  ctrlStrobes_t strobes;
  logic faultInt;

  txFaultCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .txDisable(txDisable), .strobes(strobes)
  );

  txFaultDatapath #(.SAMPLE_W(SAMPLE_W), .SLOW_W(SLOW_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .biasSample(biasSample), .powerSample(powerSample),
    .biasHiLimit(biasHiLimit), .powerHiLimit(powerHiLimit),
    .powerLoLimit(powerLoLimit), .slowAlarms(slowAlarms),
    .slowEnables(slowEnables), .shutdownSig(shutdownSig),
    .faultInt(faultInt), .statusOne(statusOne), .statusTwo(statusTwo)
  );

  assign faultOe = ~faultInt;

  p_oe_tracks_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultOe == !statusOne[2]);
endmodule

// File: tb/test_txFaultAgg.sv
module test_txFaultAgg;
  localparam int SW = 12;
  localparam int LW = 8;

  logic clk = 0;
  logic rstN = 0;
  logic sampleValid = 0;
  logic [SW-1:0] biasSample = 0, powerSample = 100;
  logic [SW-1:0] biasHiLimit = 100, powerHiLimit = 200, powerLoLimit = 50;
  logic [LW-1:0] slowAlarms = 0, slowEnables = 0;
  logic shutdownSig = 0, txDisable = 0;
  logic faultOe;
  logic [7:0] statusOne, statusTwo;

  int total = 0;
  int failed = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  txFaultAgg i_txFaultAgg (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .biasSample(biasSample), .powerSample(powerSample),
    .biasHiLimit(biasHiLimit), .powerHiLimit(powerHiLimit),
    .powerLoLimit(powerLoLimit), .slowAlarms(slowAlarms),
    .slowEnables(slowEnables), .shutdownSig(shutdownSig),
    .txDisable(txDisable), .faultOe(faultOe),
    .statusOne(statusOne), .statusTwo(statusTwo)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failed++; total++;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [SW-1:0] b, input logic [SW-1:0] p);
    @(negedge clk);
    biasSample = b; powerSample = p; sampleValid = 1;
    @(negedge clk);
    sampleValid = 0; biasSample = 0; powerSample = 100;
  endtask

  task automatic clearFlags();
    @(negedge clk); txDisable = 1;
    repeat (3) @(negedge clk);
    txDisable = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 statusTwo reset", statusTwo, 8'h00);
    check("R9 statusOne reset", statusOne, 8'h00);
    check("R7 faultOe reset", {7'd0, faultOe}, 8'h01);
  endtask

  task automatic t_bias();
    strobe(100, 100);
    check("R1 bias equal to ceiling", statusTwo, 8'h00);
    strobe(101, 100);
    check("R1 bias over ceiling", statusTwo, 8'h08);
    check("R8 statusOne with interrupt", statusOne, 8'h05);
    check("R7 pin released", {7'd0, faultOe}, 8'h00);
    strobe(10, 100);
    check("R4 flag sticky", statusTwo, 8'h08);
  endtask

  task automatic t_clear();
    @(negedge clk); txDisable = 1;
    @(negedge clk);
    @(negedge clk);
    check("R5 not yet cleared after two edges", statusTwo, 8'h08);
    @(negedge clk);
    check("R5 cleared after third edge", statusTwo, 8'h00);
    strobe(0, 250);
    repeat (4) @(negedge clk);
    check("R10 held disable keeps flag", statusTwo, 8'h02);
    txDisable = 0;
    repeat (4) @(negedge clk);
    check("R10 falling disable keeps flag", statusTwo, 8'h02);
  endtask

  task automatic t_power();
    strobe(0, 150);
    check("R4 in-range sample keeps flag", statusTwo, 8'h02);
    clearFlags();
    strobe(0, 49);
    check("R3 power under floor", statusTwo, 8'h01);
    strobe(0, 50);
    strobe(0, 201);
    check("R2 power over ceiling", statusTwo, 8'h03);
    clearFlags();
    strobe(0, 200);
    check("R2 power equal to ceiling", statusTwo, 8'h00);
  endtask

  task automatic t_noStrobe();
    @(negedge clk);
    biasSample = 4000; powerSample = 4000;
    repeat (3) @(negedge clk);
    check("R11 no strobe no flag", statusTwo, 8'h00);
    powerSample = 0;
    repeat (2) @(negedge clk);
    check("R11 no strobe low power", statusTwo, 8'h00);
    biasSample = 0; powerSample = 100;
  endtask

  task automatic t_slow();
    @(negedge clk); slowAlarms = 8'h10; slowEnables = 8'h0F;
    #1 check("R6 masked slow alarm", statusOne, 8'h00);
    slowEnables = 8'h10;
    #1 check("R6 enabled slow alarm", statusOne, 8'h05);
    check("R7 pin released by slow alarm", {7'd0, faultOe}, 8'h00);
    shutdownSig = 1;
    #1 check("R8 shutdown bit", statusOne, 8'h07);
    slowAlarms = 0; slowEnables = 0; shutdownSig = 0;
    #1 check("R6 interrupt drops", statusOne, 8'h00);
  endtask

  task automatic t_priority();
    @(negedge clk); txDisable = 1;
    @(negedge clk);
    @(negedge clk);
    biasSample = 500; powerSample = 1; sampleValid = 1;
    @(negedge clk);
    sampleValid = 0; biasSample = 0; powerSample = 100;
    check("R5 clear beats same-edge set", statusTwo, 8'h00);
    txDisable = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_bias();
    t_clear();
    t_power();
    t_noStrobe();
    t_slow();
    t_priority();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule